// File: doc/BRIEF.md
# Per-Locality Maskable Interrupt Controller

This block holds an interrupt-enable word and an interrupt-status word for each of several requester localities. All localities share one interrupt output line. Event producers elsewhere in the chip pulse a request that names a target locality and a mask of event bits. The block latches into that locality's status only the bits that software has enabled, and only while that locality's master enable is on. Each latch raises the shared line.

Software reaches the block through a single-cycle write strobe and a combinational read port, with a register select and a locality index on both. Only the locality that currently owns the interface (the `active_loc` input) may change its enable or status words. Status bits are cleared by writing ones. A clear that empties the status of the written locality lowers the line. A third register returns a fixed interrupt vector and ignores writes.

Event bits: data available is bit 0, status valid is bit 1, locality change is bit 2, command ready is bit 7. In the enable word, bit 31 is the master enable and bits 4:3 hold the polarity field, where 2'b01 means low level.

Top module: `irq_status_ctl`

## Requirements
- R1: An event for locality L sets bits in L's status, and sets the line high on the next clock edge, only for bits that are among {0,1,2,7}, are set in L's enable word, and only while enable bit 31 of L is 1. In every other case the status does not change.
- R2: An event whose locality index is NUM_LOC or larger (0xFF included) changes no status word and does not raise the line.
- R3: A write to the enable word (select 0) or to the status word (select 2) whose locality index differs from `active_loc` changes nothing. An `active_loc` of NUM_LOC or more blocks all such writes.
- R4: An accepted enable write stores `wdata & 32'h8000_009F`, so it keeps only bit 31, bits 4:3 and event bits 0, 1, 2 and 7.
- R5: An accepted status write clears the written ones among bits {0,1,2,7}. If it clears at least one set bit and leaves that locality's status zero, the line goes low, even when other localities still hold status bits.
- R6: After reset, every enable word reads 32'h0000_0008 (polarity low level, all enables off), every status word reads 0, and the line is low.
- R7: The vector register (select 1) always reads the parameter VECTOR_VALUE, and writes to it are ignored.
- R8: If an event and a clear hit the same status bit in the same cycle, the bit ends set and the line stays high.
- R9: A status write that leaves the locality's status nonzero, or that clears no set bit, leaves the line unchanged.
- R10: Reads have no side effects. Select 3, or any locality index of NUM_LOC or more, reads 32'hFFFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_loc | input | LOC_W | Locality that currently owns the interface |
| evt_req | input | 1 | Event request strobe |
| evt_loc | input | LOC_W | Target locality of the event |
| evt_mask | input | 32 | Event bits requested |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 enable, 1 vector, 2 status, 3 none |
| reg_loc | input | LOC_W | Locality index of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| irq_o | output | 1 | Shared interrupt line, level, active high |

## Verification
The bench builds the block with its defaults: five localities and an 8-bit locality index. With that setting it can sweep every combination of master enable, the four per-event enables and the sixteen event subsets on every locality, so the full masking function is compared against an arithmetic model. The 8-bit index also lets the bench drive the out-of-range codes 5 and 0xFF as event targets, write owners and read indices. Directed sequences cover the cases that hinge on timing between localities: one locality dropping the shared line while another still holds status, no-op clears, and an event meeting a clear in the same cycle.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
    localparam int DATA_W        = 32;
    localparam int GLOBAL_EN_BIT = 31;

    localparam logic [DATA_W-1:0] EVT_SUPPORTED = 32'h0000_0087;
    localparam logic [DATA_W-1:0] EN_WRITABLE   = 32'h8000_009F;
    localparam logic [DATA_W-1:0] EN_RESET      = 32'h0000_0008;
    localparam logic [DATA_W-1:0] RD_INVALID    = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_VECTOR = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] en;
        logic [DATA_W-1:0] st;
    } loc_state_t;

    typedef struct packed {
        logic level;
    } line_state_t;
endpackage

// File: rtl/irq_evt_route.sv
module irq_evt_route
    import irq_ctl_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 8
) (
    input  logic              evt_req,
    input  logic [LOC_W-1:0]  evt_loc,
    input  logic [DATA_W-1:0] evt_mask,
    output logic [DATA_W-1:0] loc_mask [NUM_LOC]
);
    for (genvar i = 0; i < NUM_LOC; i++) begin : g_route
        assign loc_mask[i] = (evt_req && (evt_loc == LOC_W'(i))) ? evt_mask : '0;
    end
endmodule

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
    import irq_ctl_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 8
) (
    input  logic               reg_wr,
    input  logic [1:0]         reg_sel,
    input  logic [LOC_W-1:0]   reg_loc,
    input  logic [LOC_W-1:0]   active_loc,
    output logic [NUM_LOC-1:0] en_wr,
    output logic [NUM_LOC-1:0] st_wr
);
    logic owner_ok;

    assign owner_ok = reg_wr && (reg_loc == active_loc);

    for (genvar i = 0; i < NUM_LOC; i++) begin : g_dec
        logic hit;
        assign hit      = owner_ok && (reg_loc == LOC_W'(i));
        assign en_wr[i] = hit && (reg_sel_e'(reg_sel) == SEL_ENABLE);
        assign st_wr[i] = hit && (reg_sel_e'(reg_sel) == SEL_STATUS);
    end
endmodule

// File: rtl/irq_loc_bank.sv
module irq_loc_bank
    import irq_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic              st_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] evt_mask,
    output logic [DATA_W-1:0] en_o,
    output logic [DATA_W-1:0] st_o,
    output logic              raise_o,
    output logic              drop_o
);
    loc_state_t        state_d, state_q;
    logic [DATA_W-1:0] set_bits;
    logic [DATA_W-1:0] clr_bits;

    always_comb begin
        state_d  = state_q;
        set_bits = state_q.en[GLOBAL_EN_BIT] ? (evt_mask & state_q.en & EVT_SUPPORTED) : '0;
        clr_bits = st_wr ? (wdata & EVT_SUPPORTED) : '0;
        if (en_wr) begin
            state_d.en = wdata & EN_WRITABLE;
        end
        state_d.st = (state_q.st & ~clr_bits) | set_bits;
        raise_o    = |set_bits;
        drop_o     = (|(state_q.st & clr_bits)) && (state_d.st == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{en: EN_RESET, st: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign en_o = state_q.en;
    assign st_o = state_q.st;

    AST_MASTER_OFF_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.en[GLOBAL_EN_BIT] |=> ((state_q.st & ~$past(state_q.st)) == '0)); // R1
    AST_STATUS_SUPPORTED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st & ~EVT_SUPPORTED) == '0); // R1
    AST_ENABLE_LEGAL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.en & ~EN_WRITABLE) == '0); // R4
endmodule

// File: rtl/irq_line_reg.sv
module irq_line_reg
    import irq_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise_any,
    input  logic drop_any,
    output logic irq_o
);
    line_state_t line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (raise_any) begin
            line_d.level = 1'b1;
        end else if (drop_any) begin
            line_d.level = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '{level: 1'b0};
        end else begin
            line_q <= line_d;
        end
    end

    assign irq_o = line_q.level;

    AST_RAISE_BEATS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_any && drop_any) |=> irq_o); // R8
endmodule

// File: rtl/irq_status_ctl.sv
module irq_status_ctl
    import irq_ctl_pkg::*;
#(
    parameter int                NUM_LOC      = 5,
    parameter int                LOC_W        = 8,
    parameter logic [DATA_W-1:0] VECTOR_VALUE = 32'h0000_000B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LOC_W-1:0]  active_loc,
    input  logic              evt_req,
    input  logic [LOC_W-1:0]  evt_loc,
    input  logic [DATA_W-1:0] evt_mask,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [LOC_W-1:0]  reg_loc,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    localparam logic [LOC_W-1:0] LOC_LIMIT = LOC_W'(NUM_LOC);

    logic [DATA_W-1:0]  loc_mask [NUM_LOC];
    logic [DATA_W-1:0]  en_w     [NUM_LOC];
    logic [DATA_W-1:0]  st_w     [NUM_LOC];
    logic [NUM_LOC-1:0] en_wr, st_wr, raise_vec, drop_vec;

    irq_evt_route #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_route (
        .evt_req  (evt_req),
        .evt_loc  (evt_loc),
        .evt_mask (evt_mask),
        .loc_mask (loc_mask)
    );

    irq_wr_decode #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_dec (
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_loc    (reg_loc),
        .active_loc (active_loc),
        .en_wr      (en_wr),
        .st_wr      (st_wr)
    );

    for (genvar i = 0; i < NUM_LOC; i++) begin : g_bank
        irq_loc_bank u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_wr    (en_wr[i]),
            .st_wr    (st_wr[i]),
            .wdata    (reg_wdata),
            .evt_mask (loc_mask[i]),
            .en_o     (en_w[i]),
            .st_o     (st_w[i]),
            .raise_o  (raise_vec[i]),
            .drop_o   (drop_vec[i])
        );

        AST_FOREIGN_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_sel_e'(reg_sel) == SEL_ENABLE && reg_loc == LOC_W'(i)
             && active_loc != LOC_W'(i)) |=> $stable(en_w[i])); // R3
    end

    irq_line_reg u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .raise_any (|raise_vec),
        .drop_any  (|drop_vec),
        .irq_o     (irq_o)
    );

    always_comb begin
        reg_rdata = RD_INVALID;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (reg_loc == LOC_W'(i)) begin
                case (reg_sel_e'(reg_sel))
                    SEL_ENABLE: reg_rdata = en_w[i];
                    SEL_VECTOR: reg_rdata = VECTOR_VALUE;
                    SEL_STATUS: reg_rdata = st_w[i];
                    default:    reg_rdata = RD_INVALID;
                endcase
            end
        end
    end

    AST_RISE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(evt_req)); // R1
    AST_INVALID_EVENT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_req && evt_loc >= LOC_LIMIT) |=> !$rose(irq_o)); // R2
    AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(reg_wr && reg_sel_e'(reg_sel) == SEL_STATUS
                               && reg_loc == active_loc)); // R5
endmodule

// File: tb/test_irq_status_ctl.sv
`timescale 1ns/1ps
module test_irq_status_ctl;
    localparam int          NL  = 5;
    localparam logic [31:0] VEC = 32'h0000_000B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  active_loc = 8'd0;
    logic        evt_req = 1'b0;
    logic [7:0]  evt_loc = 8'd0;
    logic [31:0] evt_mask = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  reg_loc = 8'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_status_ctl #(.NUM_LOC(NL), .LOC_W(8), .VECTOR_VALUE(VEC)) i_irq_status_ctl (
        .clk(clk), .rst_n(rst_n), .active_loc(active_loc),
        .evt_req(evt_req), .evt_loc(evt_loc), .evt_mask(evt_mask),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_loc(reg_loc),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [1:0] sel, input logic [7:0] loc,
                        input logic [31:0] data, input logic ev, input logic [7:0] eloc,
                        input logic [31:0] em);
        @(negedge clk);
        reg_wr = wr; reg_sel = sel; reg_loc = loc; reg_wdata = data;
        evt_req = ev; evt_loc = eloc; evt_mask = em;
        @(negedge clk);
        reg_wr = 1'b0; evt_req = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] loc, input logic [31:0] data);
        step(1'b1, sel, loc, data, 1'b0, 8'd0, 32'd0);
    endtask

    task automatic ev(input logic [7:0] loc, input logic [31:0] m);
        step(1'b0, 2'd0, 8'd0, 32'd0, 1'b1, loc, m);
    endtask

    task automatic rd(input logic [1:0] sel, input logic [7:0] loc, output logic [31:0] v);
        reg_sel = sel; reg_loc = loc;
        #1;
        v = reg_rdata;
    endtask

    function automatic logic [31:0] map4(input logic [3:0] x);
        return (32'(x[3]) << 7) | 32'(x[2:0]);
    endfunction

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        for (int l = 0; l < NL; l++) begin
            rd(2'd0, 8'(l), v); chk("R6 enable reset", v, 32'h0000_0008);
            rd(2'd2, 8'(l), v); chk("R6 status reset", v, 32'h0);
        end
        chk("R6 line reset", 32'(irq_o), 32'd0);

        // R7 vector, R10 invalid reads
        wr(2'd1, 8'd0, 32'h55);
        rd(2'd1, 8'd0, v); chk("R7 vector fixed", v, VEC);
        rd(2'd3, 8'd0, v); chk("R10 select 3", v, 32'hFFFF_FFFF);
        rd(2'd2, 8'd5, v); chk("R10 loc 5 read", v, 32'hFFFF_FFFF);
        rd(2'd0, 8'hFF, v); chk("R10 loc FF read", v, 32'hFFFF_FFFF);

        // R1 R4 R5 sweep
        for (int l = 0; l < NL; l++) begin
            active_loc = 8'(l);
            for (int e = 0; e < 32; e++) begin
                logic [31:0] enw;
                enw = map4(4'(e)) | (32'(e >> 4) << 31);
                wr(2'd0, 8'(l), enw | 32'h0100_0070);
                rd(2'd0, 8'(l), v); chk("R4 enable keep", v, enw | 32'h10);
                for (int s = 0; s < 16; s++) begin
                    logic [31:0] exp_st;
                    exp_st = (e >= 16) ? (map4(4'(s)) & enw & 32'h87) : 32'h0;
                    ev(8'(l), map4(4'(s)) | 32'h0000_0160);
                    rd(2'd2, 8'(l), v); chk("R1 latch", v, exp_st);
                    chk("R1 line", 32'(irq_o), 32'(exp_st != 0));
                    rd(2'd2, 8'(l), v); chk("R10 reread", v, exp_st);
                    wr(2'd2, 8'(l), 32'hFFFF_FFFF);
                    rd(2'd2, 8'(l), v); chk("R5 cleared", v, 32'h0);
                    chk("R5 line low", 32'(irq_o), 32'd0);
                end
            end
        end

        // R2 invalid localities
        for (int l = 0; l < NL; l++) begin
            active_loc = 8'(l);
            wr(2'd0, 8'(l), 32'h8000_009F);
        end
        ev(8'd5, 32'h87);
        ev(8'hFF, 32'h87);
        chk("R2 line", 32'(irq_o), 32'd0);
        for (int l = 0; l < NL; l++) begin
            rd(2'd2, 8'(l), v); chk("R2 status", v, 32'h0);
        end

        // R3 no active owner blocks writes
        active_loc = 8'hFF;
        wr(2'd0, 8'd3, 32'h0);
        rd(2'd0, 8'd3, v); chk("R3 no owner", v, 32'h8000_009F);

        // R9 / R5 shared line
        active_loc = 8'd0;
        ev(8'd0, 32'h1);
        ev(8'd1, 32'h2);
        chk("R1 line up", 32'(irq_o), 32'd1);
        active_loc = 8'd1;
        wr(2'd2, 8'd1, 32'h1);
        chk("R9 no-op clear line", 32'(irq_o), 32'd1);
        rd(2'd2, 8'd1, v); chk("R9 no-op clear status", v, 32'h2);
        wr(2'd2, 8'd0, 32'hFFFF_FFFF);
        rd(2'd2, 8'd0, v); chk("R3 foreign status write", v, 32'h1);
        wr(2'd0, 8'd2, 32'h0);
        rd(2'd0, 8'd2, v); chk("R3 foreign enable write", v, 32'h8000_009F);
        wr(2'd2, 8'd1, 32'h2);
        chk("R5 drop with other pending", 32'(irq_o), 32'd0);
        rd(2'd2, 8'd0, v); chk("R5 other kept", v, 32'h1);

        active_loc = 8'd0;
        ev(8'd0, 32'h4);
        wr(2'd2, 8'd0, 32'h1);
        rd(2'd2, 8'd0, v); chk("R9 partial status", v, 32'h4);
        chk("R9 partial line", 32'(irq_o), 32'd1);
        step(1'b1, 2'd2, 8'd0, 32'h4, 1'b1, 8'd0, 32'h4);
        rd(2'd2, 8'd0, v); chk("R8 event wins status", v, 32'h4);
        chk("R8 event wins line", 32'(irq_o), 32'd1);
        wr(2'd2, 8'd0, 32'h4);
        chk("R5 final drop", 32'(irq_o), 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule